// File: doc/BRIEF.md
# Submersible Emergency Escalation Controller

This block supervises a small underwater vehicle. It takes already-digitized threshold flags from the pressure, bilge, battery and temperature sensors and turns them into actuator commands. It fires the gas canister valve and the keel vent valve as single fixed-width solenoid pulses, sheds nonessential loads, selects the reserve battery, and raises a surfacing request together with fixed attitude and propulsion command codes.

Recovery happens in three stages. In normal cruise, only the pressure-balancing valves react. An abort condition moves the controller into an ascent stage, which holds until reset. An ascent that shows no exterior-pressure change for a programmable number of cycles escalates to a final rescue stage. A double battery failure also escalates to that stage. The rescue stage fires the marker buoy once and detaches the rescue unit from the main bus. It then blinks a low-duty light and gates an intermittent acoustic beacon from a shared tick prescaler.

The rescue stage is left only through reset. The surrounding firmware supplies the ascent timeout limit.

Top module: `subsea_guard`

## Requirements
- R1: While reset is held, and for the cycles right after its release, all valve, buoy, surface, abort, shed, reserve, rescue, light and beacon outputs are 0, and the plane, rudder and propulsion codes are 00 (follow mission).
- R2: A rising edge of `hull_dp_over` makes `co2_fire` high for exactly PULSE_W cycles, starting the cycle after the edge is sampled. Holding the flag high, or a new edge while a pulse is running, starts no further pulse.
- R3: A rising edge of `ext_below_int` makes `keel_vent` high for exactly PULSE_W cycles, with the same retrigger rule as R2.
- R4: A rising edge of `bilge_high` starts a `co2_fire` pulse and a `keel_vent` pulse, and the controller enters ascent, all in the same cycle.
- R5: `main_batt_low` sets `load_shed` and `resv_sel` one cycle later, latches them until reset, and moves a cruising controller into ascent.
- R6: `motor_overtemp` or `batt_temp_fault` moves a cruising controller into ascent, with `mission_abort` high.
- R7: In ascent the outputs are `surface_req`=1, `plane_cmd`=01 (mild rise), `rudder_cmd`=01 (centred) and `prop_cmd`=10 (half ahead).
- R8: In ascent, a cycle with `ext_press_moved` high restarts the wait. Once the wait counter has reached `nopress_limit` with no movement, the next cycle enters rescue, which is nopress_limit+1 cycles after the last movement or after entry.
- R9: `main_batt_low` and `resv_batt_low` high together move the controller into rescue on the next cycle, from cruise or from ascent.
- R10: Entry to rescue gives one `buoy_fire` pulse of PULSE_W cycles. It also raises `rescue_mode` and `load_shed` and sets `prop_cmd`=01 (stop).
- R11: In rescue, `led_on` is high for the first TICK_DIV cycles of every 256·TICK_DIV-cycle window, counted from the first rescue cycle.
- R12: In rescue, `beacon_on` is high for the first BEACON_ON·TICK_DIV cycles of every BEACON_PERIOD·TICK_DIV-cycle window.
- R13: Ascent and rescue hold when all flags clear. Rescue is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hull_dp_over | input | 1 | Hull differential pressure above limit |
| ext_below_int | input | 1 | Exterior pressure below interior pressure |
| bilge_high | input | 1 | Bilge water above threshold |
| main_batt_low | input | 1 | Main battery low |
| resv_batt_low | input | 1 | Reserve battery low |
| motor_overtemp | input | 1 | Motor temperature too high |
| batt_temp_fault | input | 1 | Battery compartment temperature out of range |
| ext_press_moved | input | 1 | Exterior pressure change observed this cycle |
| nopress_limit | input | CNT_W | Ascent no-movement limit in cycles |
| co2_fire | output | 1 | Gas canister valve pulse |
| keel_vent | output | 1 | Keel vent valve pulse |
| buoy_fire | output | 1 | Marker buoy release pulse |
| surface_req | output | 1 | Surfacing request |
| mission_abort | output | 1 | Mission abort |
| load_shed | output | 1 | Disconnect nonessential loads |
| resv_sel | output | 1 | Select reserve battery |
| rescue_mode | output | 1 | Rescue unit detached from main bus |
| beacon_on | output | 1 | Acoustic beacon gate |
| led_on | output | 1 | Rescue light gate |
| plane_cmd | output | 2 | Dive plane code: 00 mission, 01 mild rise |
| rudder_cmd | output | 2 | Rudder code: 00 mission, 01 centred |
| prop_cmd | output | 2 | Propulsion code: 00 mission, 01 stop, 10 half ahead |

## Verification
Assertions check several rules on every cycle:
- A running solenoid pulse is never reloaded.
- Rescue never leaves, and ascent never returns to cruise.
- Two low batteries always lead to rescue.
- The reserve-battery latch holds.
- The ascent codes match the stage.
- The buoy fires only in rescue.
- The light and beacon slot counters wrap correctly.

The exact pulse lengths, the timeout count including the restart on movement, and the full light and beacon duty patterns over a complete 256-tick window can only be shown by the bench's scenarios, compared every cycle against a behavioural model.

// File: rtl/subsea_pkg.sv
package subsea_pkg;
  typedef enum logic [1:0] {
    ST_CRUISE = 2'd0,
    ST_ASCEND = 2'd1,
    ST_RESCUE = 2'd2
  } stage_t;

  localparam logic [1:0] PLANE_MISSION  = 2'b00;
  localparam logic [1:0] PLANE_RISE     = 2'b01;
  localparam logic [1:0] RUDDER_MISSION = 2'b00;
  localparam logic [1:0] RUDDER_CENTRE  = 2'b01;
  localparam logic [1:0] PROP_MISSION   = 2'b00;
  localparam logic [1:0] PROP_STOP      = 2'b01;
  localparam logic [1:0] PROP_HALF      = 2'b10;
endpackage

// File: rtl/sg_pulse.sv
module sg_pulse #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic fire
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy)      cnt_d = cnt_q - 1'b1;
    else if (trig) cnt_d = CW'(WIDTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = busy;

  // R2/R3/R10: a running pulse is never restarted by a new trigger
  assert_no_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sg_blink.sv
module sg_blink #(
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned LED_SLOTS     = 256,
  parameter int unsigned BEACON_PERIOD = 64,
  parameter int unsigned BEACON_ON     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic led_on,
  output logic beacon_on
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned LW = $clog2(LED_SLOTS);
  localparam int unsigned BW = $clog2(BEACON_PERIOD);

  logic [PW-1:0] pre_q, pre_d;
  logic [LW-1:0] led_q, led_d;
  logic [BW-1:0] bcn_q, bcn_d;
  logic          tick;

  assign tick = en && (pre_q == PW'(TICK_DIV - 1));

  always_comb begin
    pre_d = pre_q;
    led_d = led_q;
    bcn_d = bcn_q;
    if (!en) begin
      pre_d = '0;
      led_d = '0;
      bcn_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        led_d = (led_q == LW'(LED_SLOTS - 1))     ? '0 : led_q + 1'b1;
        bcn_d = (bcn_q == BW'(BEACON_PERIOD - 1)) ? '0 : bcn_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      led_q <= '0;
      bcn_q <= '0;
    end else begin
      pre_q <= pre_d;
      led_q <= led_d;
      bcn_q <= bcn_d;
    end
  end

  assign led_on    = en && (led_q == '0);
  assign beacon_on = en && (bcn_q < BW'(BEACON_ON));

  assert_led_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && led_q == LW'(LED_SLOTS - 1)) |=> led_on);
  assert_beacon_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && bcn_q == BW'(BEACON_PERIOD - 1)) |=> beacon_on);
endmodule

// File: rtl/sg_stage.sv
module sg_stage
  import subsea_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bilge_high,
  input  logic             main_low,
  input  logic             resv_low,
  input  logic             motor_hot,
  input  logic             batt_hot,
  input  logic             moved,
  input  logic [CNT_W-1:0] limit,
  output stage_t           stage_q,
  output logic             rescue_entry,
  output logic             shed_q
);
  stage_t           stage_d;
  logic [CNT_W-1:0] wait_q, wait_d;
  logic             shed_d;
  logic             both_low, abort_cause, stalled;

  assign both_low    = main_low && resv_low;
  assign abort_cause = bilge_high || main_low || motor_hot || batt_hot;
  assign stalled     = !moved && (wait_q >= limit);

  always_comb begin
    stage_d = stage_q;
    unique case (stage_q)
      ST_CRUISE: begin
        if (both_low)         stage_d = ST_RESCUE;
        else if (abort_cause) stage_d = ST_ASCEND;
      end
      ST_ASCEND: if (both_low || stalled) stage_d = ST_RESCUE;
      ST_RESCUE: stage_d = ST_RESCUE;
      default:   stage_d = ST_RESCUE;
    endcase
  end

  always_comb begin
    if (stage_q != ST_ASCEND || moved) wait_d = '0;
    else if (wait_q < limit)           wait_d = wait_q + 1'b1;
    else                               wait_d = wait_q;
  end

  assign shed_d       = shed_q || main_low;
  assign rescue_entry = (stage_q != ST_RESCUE) && (stage_d == ST_RESCUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_CRUISE;
      wait_q  <= '0;
      shed_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      wait_q  <= wait_d;
      shed_q  <= shed_d;
    end
  end

  assert_rescue_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_RESCUE) |=> (stage_q == ST_RESCUE));
  assert_ascend_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_ASCEND) |=> (stage_q != ST_CRUISE));
  assert_double_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (main_low && resv_low) |=> (stage_q == ST_RESCUE));
  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_ASCEND && $stable(limit) && wait_q <= limit) |=> (wait_q <= limit));
endmodule

// File: rtl/subsea_guard.sv
module subsea_guard
  import subsea_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned PULSE_W       = 4,
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned BEACON_PERIOD = 64,
  parameter int unsigned BEACON_ON     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hull_dp_over,
  input  logic             ext_below_int,
  input  logic             bilge_high,
  input  logic             main_batt_low,
  input  logic             resv_batt_low,
  input  logic             motor_overtemp,
  input  logic             batt_temp_fault,
  input  logic             ext_press_moved,
  input  logic [CNT_W-1:0] nopress_limit,
  output logic             co2_fire,
  output logic             keel_vent,
  output logic             buoy_fire,
  output logic             surface_req,
  output logic             mission_abort,
  output logic             load_shed,
  output logic             resv_sel,
  output logic             rescue_mode,
  output logic             beacon_on,
  output logic             led_on,
  output logic [1:0]       plane_cmd,
  output logic [1:0]       rudder_cmd,
  output logic [1:0]       prop_cmd
);
  localparam int unsigned LED_SLOTS = 256;
  localparam int unsigned NSOL      = 3;

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic prev_hull_q, prev_ext_q, prev_bilge_q;
  logic rise_hull, rise_ext, rise_bilge;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      prev_hull_q  <= 1'b0;
      prev_ext_q   <= 1'b0;
      prev_bilge_q <= 1'b0;
    end else begin
      prev_hull_q  <= hull_dp_over;
      prev_ext_q   <= ext_below_int;
      prev_bilge_q <= bilge_high;
    end
  end

  assign rise_hull  = hull_dp_over  && !prev_hull_q;
  assign rise_ext   = ext_below_int && !prev_ext_q;
  assign rise_bilge = bilge_high    && !prev_bilge_q;

  stage_t stage_q;
  logic   rescue_entry, shed_q;

  sg_stage #(.CNT_W(CNT_W)) u_stage (
    .clk          (clk),
    .rst_n        (rst_i),
    .bilge_high   (bilge_high),
    .main_low     (main_batt_low),
    .resv_low     (resv_batt_low),
    .motor_hot    (motor_overtemp),
    .batt_hot     (batt_temp_fault),
    .moved        (ext_press_moved),
    .limit        (nopress_limit),
    .stage_q      (stage_q),
    .rescue_entry (rescue_entry),
    .shed_q       (shed_q)
  );

  logic [NSOL-1:0] sol_trig, sol_fire;
  assign sol_trig[0] = rise_hull || rise_bilge;
  assign sol_trig[1] = rise_ext  || rise_bilge;
  assign sol_trig[2] = rescue_entry;

  for (genvar g = 0; g < NSOL; g++) begin : g_sol
    sg_pulse #(.WIDTH(PULSE_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_i),
      .trig  (sol_trig[g]),
      .fire  (sol_fire[g])
    );
  end

  assign co2_fire  = sol_fire[0];
  assign keel_vent = sol_fire[1];
  assign buoy_fire = sol_fire[2];

  logic in_rescue, in_ascend;
  assign in_rescue = (stage_q == ST_RESCUE);
  assign in_ascend = (stage_q == ST_ASCEND);

  sg_blink #(
    .TICK_DIV      (TICK_DIV),
    .LED_SLOTS     (LED_SLOTS),
    .BEACON_PERIOD (BEACON_PERIOD),
    .BEACON_ON     (BEACON_ON)
  ) u_blink (
    .clk       (clk),
    .rst_n     (rst_i),
    .en        (in_rescue),
    .led_on    (led_on),
    .beacon_on (beacon_on)
  );

  always_comb begin
    surface_req   = in_ascend || in_rescue;
    mission_abort = in_ascend || in_rescue;
    load_shed     = shed_q || in_rescue;
    resv_sel      = shed_q;
    rescue_mode   = in_rescue;
    plane_cmd     = PLANE_MISSION;
    rudder_cmd    = RUDDER_MISSION;
    prop_cmd      = PROP_MISSION;
    if (in_ascend || in_rescue) begin
      plane_cmd  = PLANE_RISE;
      rudder_cmd = RUDDER_CENTRE;
      prop_cmd   = in_rescue ? PROP_STOP : PROP_HALF;
    end
  end

  assert_reserve_latched_R5: assert property (@(posedge clk) disable iff (!rst_i)
    resv_sel |=> resv_sel);
  assert_ascend_codes_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (surface_req && !rescue_mode) |-> (prop_cmd == PROP_HALF && plane_cmd == PLANE_RISE));
  assert_buoy_in_rescue_R10: assert property (@(posedge clk) disable iff (!rst_i)
    buoy_fire |-> rescue_mode);
  assert_bilge_valves_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (bilge_high && !prev_bilge_q && !co2_fire && !keel_vent) |=> (co2_fire && keel_vent && surface_req));
endmodule

// File: tb/subsea_guard_tb.sv
module subsea_guard_tb;
  localparam int CW = 16, PW = 4, TD = 4, BP = 64, BON = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hull = 0, extb = 0, bilge = 0, mlow = 0, rlow = 0, mhot = 0, bhot = 0, moved = 0;
  logic [CW-1:0] lim = 16'd5;
  logic co2, keel, buoy, surf, abrt, shed, resv, resc, bcn, led;
  logic [1:0] plane, rudder, prop;

  always #10 clk = ~clk;

  subsea_guard #(.CNT_W(CW), .PULSE_W(PW), .TICK_DIV(TD),
                 .BEACON_PERIOD(BP), .BEACON_ON(BON)) u_dut (
    .clk(clk), .rst_n(rst_n), .hull_dp_over(hull), .ext_below_int(extb),
    .bilge_high(bilge), .main_batt_low(mlow), .resv_batt_low(rlow),
    .motor_overtemp(mhot), .batt_temp_fault(bhot), .ext_press_moved(moved),
    .nopress_limit(lim), .co2_fire(co2), .keel_vent(keel), .buoy_fire(buoy),
    .surface_req(surf), .mission_abort(abrt), .load_shed(shed), .resv_sel(resv),
    .rescue_mode(resc), .beacon_on(bcn), .led_on(led), .plane_cmd(plane),
    .rudder_cmd(rudder), .prop_cmd(prop));

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mst = 0, wcnt = 0, c_co2 = 0, c_keel = 0, c_buoy = 0, rc = 0, rel = 0;
  bit mshed = 0, p_h = 0, p_e = 0, p_b = 0;

  task automatic model_clear();
    mst = 0; wcnt = 0; c_co2 = 0; c_keel = 0; c_buoy = 0; rc = 0;
    mshed = 0; p_h = 0; p_e = 0; p_b = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0;
      model_clear();
    end else begin
      rel++;
      if (rel <= 2) model_clear();
      else begin
        int ns;
        bit rh, re, rb, enter;
        ns = mst;
        if (mst == 0) begin
          if (mlow && rlow) ns = 2;
          else if (bilge || mlow || mhot || bhot) ns = 1;
        end else if (mst == 1) begin
          if ((mlow && rlow) || (!moved && wcnt >= int'(lim))) ns = 2;
        end
        if (mst != 1 || moved) wcnt = 0;
        else if (wcnt < int'(lim)) wcnt++;
        if (mlow) mshed = 1;
        rh = hull && !p_h; re = extb && !p_e; rb = bilge && !p_b;
        enter = (mst != 2) && (ns == 2);
        if (c_co2 > 0) c_co2--; else if (rh || rb) c_co2 = PW;
        if (c_keel > 0) c_keel--; else if (re || rb) c_keel = PW;
        if (c_buoy > 0) c_buoy--; else if (enter) c_buoy = PW;
        rc = (mst == 2) ? rc + 1 : 0;
        p_h = hull; p_e = extb; p_b = bilge;
        mst = ns;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    chk("R2", "co2_fire", co2, c_co2 > 0);
    chk("R3", "keel_vent", keel, c_keel > 0);
    chk("R10", "buoy_fire", buoy, c_buoy > 0);
    chk("R7", "surface_req", surf, mst != 0);
    chk("R6", "mission_abort", abrt, mst != 0);
    chk("R5", "load_shed", shed, mshed || mst == 2);
    chk("R5", "resv_sel", resv, mshed);
    chk("R13", "rescue_mode", resc, mst == 2);
    chk("R11", "led_on", led, mst == 2 && ((rc / TD) % 256) == 0);
    chk("R12", "beacon_on", bcn, mst == 2 && ((rc / TD) % BP) < BON);
    chk("R7", "plane_cmd", plane, mst != 0 ? 1 : 0);
    chk("R7", "rudder_cmd", rudder, mst != 0 ? 1 : 0);
    chk("R10", "prop_cmd", prop, mst == 0 ? 0 : (mst == 1 ? 2 : 1));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {hull, extb, bilge, mlow, rlow, mhot, bhot, moved} = '0;
    tick(3);
    rst_n = 1;
    tick(4);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    // R1: reset state
    chk("R1", "surface_req in reset", surf, 0);
    chk("R1", "co2 in reset", co2, 0);
    chk("R1", "prop_cmd in reset", prop, 0);
    rst_n = 1;
    tick(4);
    chk("R1", "rescue_mode after release", resc, 0);

    // R2: held flag gives one pulse, retrigger during pulse ignored
    hull = 1; tick(10); hull = 0; tick(2);
    hull = 1; tick(1); hull = 0; tick(1); hull = 1; tick(8); hull = 0;
    // R3
    extb = 1; tick(6); extb = 0; tick(5);
    chk("R13", "still cruising after valve events", surf, 0);

    // R6 and R8: abort, movement keeps the wait open, then timeout
    mhot = 1; tick(2); mhot = 0;
    chk("R6", "abort after overtemp", abrt, 1);
    repeat (6) begin moved = 1; tick(1); moved = 0; tick(2); end
    chk("R8", "no rescue while moving", resc, 0);
    moved = 1; tick(1); moved = 0;
    tick(5);
    chk("R8", "not yet rescue at limit", resc, 0);
    tick(1);
    chk("R8", "rescue after limit+1", resc, 1);
    tick(1100);
    chk("R13", "rescue sticky", resc, 1);
    do_reset();

    // R6: battery temperature
    bhot = 1; tick(1); bhot = 0; tick(3);
    chk("R6", "abort after battery temp", abrt, 1);
    do_reset();

    // R5 then R9
    mlow = 1; tick(5);
    chk("R5", "reserve selected", resv, 1);
    rlow = 1; tick(2);
    chk("R9", "rescue on double low", resc, 1);
    mlow = 0; rlow = 0; tick(20);
    chk("R5", "reserve stays latched", resv, 1);
    do_reset();

    // R9 directly from cruise
    mlow = 1; rlow = 1; tick(1);
    chk("R9", "rescue from cruise", resc, 1);
    mlow = 0; rlow = 0; tick(10);
    do_reset();

    // R4: bilge fires both valves and surfacing together
    bilge = 1; tick(1);
    chk("R4", "co2 on bilge", co2, 1);
    chk("R4", "keel on bilge", keel, 1);
    chk("R4", "surface on bilge", surf, 1);
    tick(6); bilge = 0; tick(3);
    do_reset();

    // R8: zero limit escalates one cycle after entry
    lim = 0;
    mhot = 1; tick(1); mhot = 0;
    chk("R8", "ascend with zero limit", resc, 0);
    tick(1);
    chk("R8", "rescue with zero limit", resc, 1);
    tick(10);

    finish_run();
  end
endmodule